// File: doc/BRIEF.md
# Random memory tag generator

This block produces a 4-bit allocation tag for a pointer whenever a request comes in. It keeps a 32-bit state word that holds a 16-bit pseudo-random seed and the tag it produced last. For each request it runs the seed through four shifts of a linear feedback shift register, and the bits that are shifted in form an offset. Starting from the stored tag, it then walks forward through the sixteen tag values by that offset. Excluded values are skipped and do not count as steps.

The block returns the request pointer with its tag field replaced by the chosen tag, and it writes the new tag and the advanced seed back into the state word. Two sources feed the exclusion set: a per-request mask and a configuration mask. When reseeding is enabled and the stored seed is zero, the block uses a request/valid handshake to fetch a fresh nonzero seed from an external random source. The tag walk moves at most one value per clock. Requests that arrive while an operation is in progress are dropped.

Top module: `rand_tag_gen`

## Requirements
- R1: After reset, st_q is 0 and busy, done and rnd_req are all low.
- R2: The exclusion set is req_excl OR cfg_excl. Bit k set means tag k is never produced, unless every bit is set.
- R3: When all 16 exclusion bits are set, the tag is 0. The seed still advances as in R4.
- R4: The LFSR takes four steps. In each step top = s[5]^s[3]^s[2]^s[0] and s becomes {top, s[15:1]}. Step i (i = 0..3) writes top into offset bit i.
- R5: With offset 0, the tag is the first non-excluded value found counting up from the start tag (st_q[3:0]), modulo 16, start tag included.
- R6: With a nonzero offset, the tag moves up by one, modulo 16, offset times. Each move goes past excluded values.
- R7: On completion st_q is rewritten as {8'h00, seed, 4'h0, tag}. The seed sits in bits [23:8] and the tag in bits [3:0].
- R8: If cfg_reseed_en is set and the seed is zero when the request is taken, rnd_req goes high. rnd_data is taken on a cycle with rnd_valid high. A zero value is dropped and rnd_req stays high. A nonzero value becomes the seed before the LFSR runs. With cfg_reseed_en low, a zero seed is used as it is and rnd_req stays low.
- R9: rsp_ptr equals the request pointer with bits [TAG_LSB+3:TAG_LSB] (default [59:56]) replaced by the tag. All other bits are unchanged.
- R10: done is a one-cycle pulse that comes with rsp_tag and rsp_ptr. busy is high from the cycle after a request is taken until done. req_valid and st_wr have no effect while busy is high.
- R11: While the block is idle, st_wr loads st_wdata into st_q on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a tag generation (taken when idle) |
| req_ptr | input | PTR_W | Pointer to be tagged |
| req_excl | input | 16 | Per-request exclusion mask |
| cfg_excl | input | 16 | Configured exclusion mask |
| cfg_reseed_en | input | 1 | Allow reseeding from the random source when the seed is zero |
| st_wr | input | 1 | Load the state word (taken when idle) |
| st_wdata | input | 32 | Value for the state word |
| st_q | output | 32 | State word: seed [23:8], last tag [3:0] |
| rnd_req | output | 1 | Request for a random word |
| rnd_valid | input | 1 | Random word valid |
| rnd_data | input | 16 | Random word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_tag | output | 4 | Chosen tag |
| rsp_ptr | output | PTR_W | Pointer with the tag inserted |

## Verification
Directed cases cover the special paths:
- An all-excluded mask checks that the tag is forced to 0 while the seed still moves.
- A zero seed with reseeding disabled gives a zero offset, which exercises the first-free search on its own.
- A seed chosen to give offset 1, with excluded values around the wrap point, checks that skipping and modulo-16 wrap work together.
- A reseed whose first two random words are zero shows that zeros are redrawn.
- Split masks, with some bits in the request and others in the configuration, check that the two are ORed.
- A request and a state write issued mid-operation must leave the result untouched.

Seeded random runs then mix dense and sparse masks, random pointers and occasional zero seeds. Every result is compared with a bench model of the LFSR and the tag walk.

// File: rtl/rand_tag_gen.sv
module rand_tag_gen #(
  parameter int PTR_W   = 64,
  parameter int TAG_LSB = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PTR_W-1:0] req_ptr,
  input  logic [15:0]      req_excl,
  input  logic [15:0]      cfg_excl,
  input  logic             cfg_reseed_en,
  input  logic             st_wr,
  input  logic [31:0]      st_wdata,
  output logic [31:0]      st_q,
  output logic             rnd_req,
  input  logic             rnd_valid,
  input  logic [15:0]      rnd_data,
  output logic             busy,
  output logic             done,
  output logic [3:0]       rsp_tag,
  output logic [PTR_W-1:0] rsp_ptr
);

  typedef enum logic [1:0] {S_IDLE, S_SEED, S_LFSR, S_PICK} fsm_e;

  fsm_e             fsm;
  logic [PTR_W-1:0] ptr_q;
  logic [15:0]      excl_q;
  logic [15:0]      seed_q;
  logic [3:0]       cur_q;
  logic [3:0]       rem_q;

  logic [15:0]      seed_nx;
  logic [3:0]       off_nx;
  logic [3:0]       cur_inc;
  logic             all_ex;
  logic             fin;
  logic [3:0]       fin_tag;
  logic [PTR_W-1:0] ptr_ins;

  always_comb begin
    logic top;
    seed_nx = seed_q;
    off_nx  = '0;
    for (int i = 0; i < 4; i++) begin
      top       = seed_nx[5] ^ seed_nx[3] ^ seed_nx[2] ^ seed_nx[0];
      seed_nx   = {top, seed_nx[15:1]};
      off_nx[i] = top;
    end
  end

  assign cur_inc = cur_q + 4'd1;
  assign all_ex  = &excl_q;
  assign fin     = (fsm == S_PICK) && (all_ex || (rem_q == 4'd0 && !excl_q[cur_q]));
  assign fin_tag = all_ex ? 4'd0 : cur_q;

  always_comb begin
    ptr_ins = ptr_q;
    ptr_ins[TAG_LSB +: 4] = fin_tag;
  end

  assign busy    = (fsm != S_IDLE);
  assign rnd_req = (fsm == S_SEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm     <= S_IDLE;
      ptr_q   <= '0;
      excl_q  <= '0;
      seed_q  <= '0;
      cur_q   <= '0;
      rem_q   <= '0;
      st_q    <= '0;
      done    <= 1'b0;
      rsp_tag <= '0;
      rsp_ptr <= '0;
    end else begin
      done <= 1'b0;
      case (fsm)
        S_IDLE: begin
          if (req_valid) begin
            ptr_q  <= req_ptr;
            excl_q <= req_excl | cfg_excl;
            seed_q <= st_q[23:8];
            cur_q  <= st_q[3:0];
            fsm    <= (cfg_reseed_en && st_q[23:8] == 16'd0) ? S_SEED : S_LFSR;
          end else if (st_wr) begin
            st_q <= st_wdata;
          end
        end
        S_SEED: begin
          if (rnd_valid && rnd_data != 16'd0) begin
            seed_q <= rnd_data;
            fsm    <= S_LFSR;
          end
        end
        S_LFSR: begin
          seed_q <= seed_nx;
          rem_q  <= off_nx;
          fsm    <= S_PICK;
        end
        S_PICK: begin
          if (fin) begin
            st_q    <= {8'h00, seed_q, 4'h0, fin_tag};
            rsp_tag <= fin_tag;
            rsp_ptr <= ptr_ins;
            done    <= 1'b1;
            fsm     <= S_IDLE;
          end else begin
            cur_q <= cur_inc;
            if (rem_q != 4'd0 && !excl_q[cur_inc]) rem_q <= rem_q - 4'd1;
          end
        end
        default: fsm <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rand_tag_gen_chk.sv
module rand_tag_gen_chk #(
  parameter int PTR_W   = 64,
  parameter int TAG_LSB = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             rnd_req,
  input logic [3:0]       rsp_tag,
  input logic [PTR_W-1:0] rsp_ptr,
  input logic [31:0]      st_q,
  input logic [15:0]      excl_q,
  input logic [PTR_W-1:0] ptr_q
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

  AST_TAG_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(&excl_q)) |-> !excl_q[rsp_tag]); // R2

  AST_ALL_EXCL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (&excl_q)) |-> (rsp_tag == 4'd0)); // R3

  AST_STATE_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st_q[7:4] == 4'd0 && st_q[31:24] == 8'd0 && st_q[3:0] == rsp_tag)); // R7

  AST_PTR_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rsp_ptr[TAG_LSB-1:0] == ptr_q[TAG_LSB-1:0])); // R9

  AST_PTR_TAG_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rsp_ptr[TAG_LSB +: 4] == rsp_tag)); // R9

  AST_RND_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_req |-> busy); // R8

endmodule

bind rand_tag_gen rand_tag_gen_chk #(.PTR_W(PTR_W), .TAG_LSB(TAG_LSB)) chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rnd_req(rnd_req),
  .rsp_tag(rsp_tag), .rsp_ptr(rsp_ptr), .st_q(st_q), .excl_q(excl_q), .ptr_q(ptr_q)
);

// File: tb/rand_tag_gen_test.sv
module rand_tag_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W = 64;
  localparam int TAG_LSB = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [PTR_W-1:0] req_ptr = '0;
  logic [15:0] req_excl = '0, cfg_excl = '0;
  logic cfg_reseed_en = 1'b0;
  logic st_wr = 1'b0;
  logic [31:0] st_wdata = '0;
  logic [31:0] st_q;
  logic rnd_req, rnd_valid = 1'b0;
  logic [15:0] rnd_data = '0;
  logic busy, done;
  logic [3:0] rsp_tag;
  logic [PTR_W-1:0] rsp_ptr;

  int n_chk = 0, n_err = 0;
  logic [31:0] exp_st = '0;
  logic [15:0] rnd_vals [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  rand_tag_gen #(.PTR_W(PTR_W), .TAG_LSB(TAG_LSB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ptr(req_ptr),
    .req_excl(req_excl), .cfg_excl(cfg_excl), .cfg_reseed_en(cfg_reseed_en),
    .st_wr(st_wr), .st_wdata(st_wdata), .st_q(st_q), .rnd_req(rnd_req),
    .rnd_valid(rnd_valid), .rnd_data(rnd_data), .busy(busy), .done(done),
    .rsp_tag(rsp_tag), .rsp_ptr(rsp_ptr));

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [3:0] pick(input logic [3:0] start, input logic [3:0] off,
                                      input logic [15:0] ex);
    logic [3:0] t = start;
    if (ex == 16'hffff) return 4'd0;
    if (off == 0) begin
      while (ex[t]) t = t + 4'd1;
    end else begin
      for (int k = 0; k < off; k++) begin
        t = t + 4'd1;
        while (ex[t]) t = t + 4'd1;
      end
    end
    return t;
  endfunction

  task automatic wr_state(input logic [31:0] v);
    @(negedge clk);
    st_wr = 1'b1; st_wdata = v;
    @(negedge clk);
    st_wr = 1'b0;
    exp_st = v;
    chk("R11 state load", st_q, v);
  endtask

  task automatic run(input logic [63:0] ptr, input logic [15:0] rex, input bit inject,
                     input bit expect_rnd);
    logic [15:0] s, ex;
    logic [3:0] off, tag, start;
    logic [63:0] eptr;
    int ri, di;
    bit seen, saw_rnd;
    s = exp_st[23:8]; start = exp_st[3:0]; ex = rex | cfg_excl; ri = 0;
    if (cfg_reseed_en && s == 0) begin
      while (s == 0) begin s = rnd_vals[ri]; ri++; end
    end
    off = '0;
    for (int i = 0; i < 4; i++) begin
      logic top;
      top = s[5] ^ s[3] ^ s[2] ^ s[0];
      s = {top, s[15:1]};
      off[i] = top;
    end
    tag = pick(start, off, ex);
    eptr = ptr; eptr[TAG_LSB +: 4] = tag;

    @(negedge clk);
    req_valid = 1'b1; req_ptr = ptr; req_excl = rex;
    seen = 0; saw_rnd = 0; di = 0;
    for (int c = 0; c < 200 && !seen; c++) begin
      @(negedge clk);
      req_valid = 1'b0; st_wr = 1'b0;
      if (c == 0) begin
        chk("R10 busy after request", busy, 1'b1);
        if (inject) begin
          req_valid = 1'b1; req_ptr = ~ptr; req_excl = ~rex;
          st_wr = 1'b1; st_wdata = 32'h00ff_ff0f;
        end
      end
      if (rnd_req) begin
        saw_rnd = 1;
        rnd_valid = 1'b1; rnd_data = rnd_vals[di]; di++;
      end else rnd_valid = 1'b0;
      if (done) seen = 1;
    end
    req_valid = 1'b0; st_wr = 1'b0; rnd_valid = 1'b0;
    if (!seen) begin
      n_chk++; n_err++;
      $display("FAIL R10 no done pulse actual=0 expected=1");
      return;
    end
    chk("R2 R5 R6 tag", rsp_tag, tag);
    chk("R9 pointer", rsp_ptr, eptr);
    chk("R4 R7 state", st_q, {8'h00, s, 4'h0, tag});
    chk("R8 random request use", saw_rnd, expect_rnd);
    exp_st = {8'h00, s, 4'h0, tag};
    @(negedge clk);
    chk("R10 done width", {done, busy}, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rnd_vals = '{16'h0001, 16'h0002, 16'h0003, 16'h0004};
    repeat (3) @(negedge clk);
    chk("R1 reset state", {st_q, busy, done, rnd_req}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {st_q, busy, done, rnd_req}, '0);

    // R3 all excluded
    wr_state(32'h0000_ab05);
    cfg_excl = 16'hff00;
    run(64'h1234_5678_9abc_def0, 16'h00ff, 0, 0);
    chk("R3 tag zero", rsp_tag, 4'd0);
    cfg_excl = 16'h0000;

    // R5 zero seed, no reseed: offset 0, first free from start
    wr_state(32'h0000_0005);
    run(64'hffff_ffff_ffff_ffff, 16'h0060, 0, 0);
    chk("R5 first free", rsp_tag, 4'd7);

    // R6 offset 1 with wrap past excluded 15 and 0
    wr_state(32'h0000_010e);
    run(64'h0f00_0000_0000_0001, 16'h8001, 0, 0);
    chk("R6 wrap skip", rsp_tag, 4'd1);
    chk("R4 seed after", st_q[23:8], 16'h1000);

    // R8 reseed with two zero draws
    rnd_vals = '{16'h0000, 16'h0000, 16'h1234, 16'h0001};
    cfg_reseed_en = 1'b1;
    wr_state(32'h0000_0003);
    run(64'h0, 16'h0000, 0, 1);
    cfg_reseed_en = 1'b0;

    // R2 masks combine
    cfg_excl = 16'h0f0f;
    wr_state(32'h00c3_a100);
    run(64'h00aa_5500_1111_2222, 16'h7070, 0, 0);
    cfg_excl = 16'h0000;

    // R10 request and write ignored while busy
    wr_state(32'h0055_5502);
    run(64'h0123_4567_89ab_cdef, 16'h0004, 1, 0);

    for (int n = 0; n < 300; n++) begin
      logic [15:0] rx;
      bit zero_seed, rnd_exp;
      cfg_excl = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0000;
      rx = ($urandom_range(0, 4) == 0) ? 16'($urandom) | 16'hf0f0 : 16'($urandom) & 16'($urandom);
      cfg_reseed_en = $urandom_range(0, 1) == 1;
      rnd_vals = '{16'($urandom_range(0, 1) ? 0 : $urandom), 16'($urandom),
                   16'($urandom), 16'h8421};
      zero_seed = $urandom_range(0, 7) == 0;
      if (zero_seed) wr_state({$urandom} & 32'hff00_00ff);
      rnd_exp = cfg_reseed_en && exp_st[23:8] == 16'd0;
      run({$urandom, $urandom}, rx, $urandom_range(0, 9) == 0, rnd_exp);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule